// File: doc/BRIEF.md
# Wormhole Crossbar Output Arbiter

This block chooses which input port may drive one output port of a router crossbar on one service level. A router places one copy of it for every pairing of output port and service level, and each copy runs on its own. An input asks for this output when its buffer holds a flit and its current destination equals the `PORT_ID` parameter. The arbiter produces a mux select and an idle flag for the crossbar datapath, plus a read strobe for the chosen input buffer.

A grant lasts for a whole wormhole packet, so flits of different packets never mix on the output. Between packets, a rotating priority shares the output among the inputs. The state machine drops back to idle when the output stalls, when the granted input changes its destination, or when its buffer runs dry. A packet that was broken off in the middle remains bound to its owner. No other input can take the output until that owner resumes, or until the owner changes its destination.

Top module: `xarb_out_fsm`

## Requirements
- R1: After a synchronous reset the arbiter is idle. `xb_idle` is 1, `xb_sel` is 0 and `rd_en` is all zero. The rotating pointer starts at input 0.
- R2: Input i is requesting when `in_avail[i]` is 1 and its destination field `in_dest[i*DEST_W +: DEST_W]` equals `PORT_ID`. From idle, a grant is made only in a cycle where `out_ready` is 1 and some input is requesting. The grant shows on `xb_sel`/`xb_idle` from the next cycle on.
- R3: When several inputs request together, the first one found scanning upward from the pointer, wrapping at `N_IN`, wins. The pointer moves to the input after the granted one only when that input's tail flit is read.
- R4: When a tail flit is read and another input is requesting, the grant passes straight to that input with no idle cycle. The finished input has the lowest priority in that choice. If no other input is requesting, the arbiter goes idle.
- R5: While granted, a cycle with `out_ready` at 0 makes the arbiter idle in the next cycle.
- R6: While granted, a destination change (`in_addr_chg`) or an empty buffer (`in_avail` 0) on the granted input makes the arbiter idle in the next cycle.
- R7: `rd_en[i]` is 1 only if input i is granted, `out_ready` is 1, `in_avail[i]` is 1 and `in_addr_chg[i]` is 0. At most one bit of `rd_en` is set.
- R8: While idle, `xb_idle` is 1, `xb_sel` is 0 and no read strobe is given. The datapath then drives zero.
- R9: If the arbiter drops to idle after at least one body flit of a packet has been read, only the owner of that packet may be granted next. This holds until the owner requests again or signals a destination change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_avail | input | N_IN | Per-input flag: a flit is waiting at the buffer head |
| in_dest | input | N_IN*DEST_W | Per-input destination output port |
| in_tail | input | N_IN | Per-input flag: the head flit ends its packet |
| in_addr_chg | input | N_IN | Per-input flag: the destination has changed |
| out_ready | input | 1 | Output can accept a flit this cycle |
| xb_sel | output | IDX_W | Registered crossbar select (granted input index) |
| xb_idle | output | 1 | Registered idle flag; the datapath drives zero |
| rd_en | output | N_IN | Read strobe to the granted input buffer |

## Verification
The bench first runs all three inputs requesting in a back-to-back chain of packets. The grant should move 0, 1, 2 at tail boundaries without any idle cycle, which separates a correct rotation from a fixed priority. One input is then given a destination for some other port, and the handoff must skip it. This shows that the destination check filters requests. A stall in the middle of a packet, while the owner's buffer is empty but others wait, shows that the packet lock holds and no interleaving occurs. A destination change, a drained buffer and a tail with no other requester each lead to idle, and each is checked on its own.

// File: rtl/xarb_pkg.sv
package xarb_pkg;
  // Next index in a ring of n entries.
  function automatic int wrap_inc(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/xarb_req_filter.sv
module xarb_req_filter #(
  parameter int N_IN    = 3,
  parameter int DEST_W  = 2,
  parameter int PORT_ID = 1
) (
  input  logic [N_IN-1:0]        avail,
  input  logic [N_IN*DEST_W-1:0] dest,
  output logic [N_IN-1:0]        req
);
  for (genvar gi = 0; gi < N_IN; gi++) begin : g_req
    assign req[gi] = avail[gi] && (dest[gi*DEST_W +: DEST_W] == DEST_W'(PORT_ID));
  end
endmodule

// File: rtl/xarb_rr_pick.sv
module xarb_rr_pick #(
  parameter int N_IN  = 3,
  parameter int IDX_W = 2
) (
  input  logic [N_IN-1:0]  req,
  input  logic [IDX_W-1:0] start,
  output logic [N_IN-1:0]  gnt_oh,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any
);
  import xarb_pkg::*;

  always_comb begin
    int pos;
    gnt_oh  = '0;
    gnt_idx = '0;
    any     = 1'b0;
    pos     = int'(start);
    for (int k = 0; k < N_IN; k++) begin
      if (!any && req[pos]) begin
        any         = 1'b1;
        gnt_oh[pos] = 1'b1;
        gnt_idx     = IDX_W'(pos);
      end
      pos = wrap_inc(pos, N_IN);
    end
  end
endmodule

// File: rtl/xarb_out_fsm.sv
module xarb_out_fsm #(
  parameter int N_IN    = 3,
  parameter int DEST_W  = 2,
  parameter int PORT_ID = 1,
  parameter int IDX_W   = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IN-1:0]        in_avail,
  input  logic [N_IN*DEST_W-1:0] in_dest,
  input  logic [N_IN-1:0]        in_tail,
  input  logic [N_IN-1:0]        in_addr_chg,
  input  logic                   out_ready,
  output logic [IDX_W-1:0]       xb_sel,
  output logic                   xb_idle,
  output logic [N_IN-1:0]        rd_en
);
  import xarb_pkg::*;

  // One-hot working state; all zero means idle.
  logic [N_IN-1:0]  g_q, g_n;
  logic [IDX_W-1:0] sel_q, sel_n;
  logic [IDX_W-1:0] ptr_q, ptr_n;
  logic [IDX_W-1:0] owner_q, owner_n;
  logic             open_q, open_n;

  logic [N_IN-1:0]  req;
  logic [N_IN-1:0]  pick_mask, pick_oh;
  logic [IDX_W-1:0] pick_start, pick_idx;
  logic             pick_any;
  logic             working;

  xarb_req_filter #(.N_IN(N_IN), .DEST_W(DEST_W), .PORT_ID(PORT_ID)) u_req (
    .avail(in_avail), .dest(in_dest), .req(req)
  );

  assign working    = |g_q;
  assign pick_mask  = working ? (req & ~g_q) : req;
  assign pick_start = working ? IDX_W'(wrap_inc(int'(sel_q), N_IN)) : ptr_q;

  xarb_rr_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick (
    .req(pick_mask), .start(pick_start),
    .gnt_oh(pick_oh), .gnt_idx(pick_idx), .any(pick_any)
  );

  assign rd_en = g_q & {N_IN{out_ready}} & in_avail & ~in_addr_chg;

  always_comb begin
    g_n     = g_q;
    sel_n   = sel_q;
    ptr_n   = ptr_q;
    owner_n = owner_q;
    open_n  = open_q;
    if (!working) begin
      if (open_q) begin
        // Packet lock: only the owner may resume.
        if (in_addr_chg[owner_q]) begin
          open_n = 1'b0;
        end else if (out_ready && req[owner_q]) begin
          g_n          = '0;
          g_n[owner_q] = 1'b1;
          sel_n        = owner_q;
        end
      end else if (out_ready && pick_any) begin
        g_n     = pick_oh;
        sel_n   = pick_idx;
        owner_n = pick_idx;
      end
    end else begin
      if (!out_ready || in_addr_chg[sel_q] || !in_avail[sel_q]) begin
        g_n   = '0;
        sel_n = '0;
        if (in_addr_chg[sel_q]) open_n = 1'b0;
      end else if (in_tail[sel_q]) begin
        ptr_n  = IDX_W'(wrap_inc(int'(sel_q), N_IN));
        open_n = 1'b0;
        if (pick_any) begin
          g_n     = pick_oh;
          sel_n   = pick_idx;
          owner_n = pick_idx;
        end else begin
          g_n   = '0;
          sel_n = '0;
        end
      end else begin
        open_n  = 1'b1;
        owner_n = sel_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_q     <= '0;
      sel_q   <= '0;
      ptr_q   <= '0;
      owner_q <= '0;
      open_q  <= 1'b0;
      xb_idle <= 1'b1;
    end else begin
      g_q     <= g_n;
      sel_q   <= sel_n;
      ptr_q   <= ptr_n;
      owner_q <= owner_n;
      open_q  <= open_n;
      xb_idle <= ~|g_n;
    end
  end

  assign xb_sel = sel_q;

  // R7: at most one read strobe.
  a_r7_rd_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_en));
  // R8: no read while idle.
  a_r8_idle_no_read: assert property (@(posedge clk) disable iff (rst)
    xb_idle |-> (rd_en == '0 && xb_sel == '0));
  // R5: stall drops the grant.
  a_r5_stall_drops: assert property (@(posedge clk) disable iff (rst)
    (!xb_idle && !out_ready) |=> xb_idle);
  // R6: destination change on the granted input drops the grant.
  a_r6_chg_drops: assert property (@(posedge clk) disable iff (rst)
    (!xb_idle && |(g_q & in_addr_chg)) |=> xb_idle);
  // R2: no grant without ready.
  a_r2_no_grant_unready: assert property (@(posedge clk) disable iff (rst)
    (xb_idle && !out_ready) |=> xb_idle);
  // R4: a finished packet hands the output to someone else or goes idle.
  a_r4_tail_moves: assert property (@(posedge clk) disable iff (rst)
    (|(rd_en & in_tail)) |=> (xb_idle || xb_sel != $past(xb_sel)));
  // R9: open packet may only be resumed by its owner.
  a_r9_lock: assert property (@(posedge clk) disable iff (rst)
    (xb_idle && open_q && !in_addr_chg[owner_q]) |=> (xb_idle || xb_sel == $past(owner_q)));
endmodule

// File: tb/tb_xarb_out_fsm.sv
`timescale 1ns/1ps
module tb_xarb_out_fsm;
  localparam int N_IN = 3;
  localparam int DEST_W = 2;

  typedef struct {
    logic [2:0] rd;
    logic       idle;
    logic [1:0] sel;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0] in_avail = '0, in_tail = '0, in_addr_chg = '0;
  logic [N_IN*DEST_W-1:0] in_dest = '0;
  logic out_ready = 1'b0;
  logic [1:0] xb_sel;
  logic xb_idle;
  logic [N_IN-1:0] rd_en;

  exp_t q[$];
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [5:0] D1 = 6'b010101;  // every input targets port 1
  localparam logic [5:0] D2 = 6'b010110;  // input 0 targets port 2

  always #10 clk = ~clk;

  xarb_out_fsm #(.N_IN(N_IN), .DEST_W(DEST_W), .PORT_ID(1)) dut (
    .clk(clk), .rst(rst), .in_avail(in_avail), .in_dest(in_dest),
    .in_tail(in_tail), .in_addr_chg(in_addr_chg), .out_ready(out_ready),
    .xb_sel(xb_sel), .xb_idle(xb_idle), .rd_en(rd_en)
  );

  task automatic step(input logic [2:0] av, input logic [5:0] de, input logic [2:0] tl,
                      input logic [2:0] ch, input logic rdy, input logic [2:0] e_rd,
                      input logic e_idle, input logic [1:0] e_sel, input string tag);
    exp_t e;
    @(negedge clk);
    in_avail = av; in_dest = de; in_tail = tl; in_addr_chg = ch; out_ready = rdy;
    e.rd = e_rd; e.idle = e_idle; e.sel = e_sel; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares outputs away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (rd_en !== e.rd || xb_idle !== e.idle || xb_sel !== e.sel) begin
          n_fail++;
          $display("FAIL %s: rd=%b idle=%b sel=%0d expected rd=%b idle=%b sel=%0d",
                   e.tag, rd_en, xb_idle, xb_sel, e.rd, e.idle, e.sel);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(3'b000, D1, 3'b000, 3'b000, 1'b0, 3'b000, 1'b1, 2'd0, "R1 reset idle");
    step(3'b111, D1, 3'b000, 3'b000, 1'b1, 3'b000, 1'b1, 2'd0, "R2 grant one cycle later");
    step(3'b111, D1, 3'b000, 3'b000, 1'b1, 3'b001, 1'b0, 2'd0, "R3 pointer 0 wins");
    step(3'b111, D1, 3'b001, 3'b000, 1'b1, 3'b001, 1'b0, 2'd0, "R4 tail read on input 0");
    step(3'b111, D1, 3'b000, 3'b000, 1'b1, 3'b010, 1'b0, 2'd1, "R4 direct handoff to 1");
    step(3'b111, D1, 3'b000, 3'b000, 1'b0, 3'b000, 1'b0, 2'd1, "R7 no read on stall");
    step(3'b101, D1, 3'b000, 3'b000, 1'b1, 3'b000, 1'b1, 2'd0, "R5 stall drops to idle");
    step(3'b111, D1, 3'b000, 3'b000, 1'b1, 3'b000, 1'b1, 2'd0, "R9 lock keeps others out");
    step(3'b111, D1, 3'b010, 3'b000, 1'b1, 3'b010, 1'b0, 2'd1, "R9 owner resumes");
    step(3'b111, D2, 3'b000, 3'b000, 1'b1, 3'b100, 1'b0, 2'd2, "R3 rotation to 2");
    step(3'b111, D2, 3'b100, 3'b000, 1'b1, 3'b100, 1'b0, 2'd2, "R4 tail on input 2");
    step(3'b111, D1, 3'b000, 3'b010, 1'b1, 3'b000, 1'b0, 2'd1, "R2 dest filter skips 0; R7 chg gates read");
    step(3'b111, D1, 3'b000, 3'b000, 1'b1, 3'b000, 1'b1, 2'd0, "R6 address change drops");
    step(3'b110, D1, 3'b000, 3'b000, 1'b1, 3'b000, 1'b0, 2'd0, "R7 empty buffer not read");
    step(3'b000, D1, 3'b000, 3'b000, 1'b1, 3'b000, 1'b1, 2'd0, "R6 drain drops");
    step(3'b010, D1, 3'b000, 3'b000, 1'b0, 3'b000, 1'b1, 2'd0, "R2 no grant while not ready");
    step(3'b010, D1, 3'b000, 3'b000, 1'b1, 3'b000, 1'b1, 2'd0, "R8 idle select zero");
    step(3'b010, D1, 3'b010, 3'b000, 1'b1, 3'b010, 1'b0, 2'd1, "R2 lone requester granted");
    step(3'b010, D1, 3'b001, 3'b000, 1'b1, 3'b000, 1'b1, 2'd0, "R4 tail with no other goes idle");
    step(3'b010, D1, 3'b000, 3'b000, 1'b1, 3'b010, 1'b0, 2'd1, "R3 pointer wrap regrant");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule